// File: doc/BRIEF.md
# Match and Capture Counter-Timer with PWM

This block is a prescaled up-counter shared by four match channels and a small set of capture channels, all programmed through a word-addressed register port. The counter advances on a step strobe that the prescaler emits once every (prescale + 1) clocks while the run bit is set. When the counter equals a channel's match value on a step, that channel fires. Its configuration then decides what follows: the counter may return to zero or halt, a status flag may be raised, and the channel's external output may be driven low, driven high or toggled.

Any match channel can instead produce a PWM waveform. Its output is then a plain comparison of the counter against its match value. A separate channel is set to wrap the counter, and that channel fixes the period. Capture channels resynchronise an asynchronous input, detect a chosen edge and record the counter. Match and capture flags are gathered in a write-one-to-clear status word, and any flag that is set raises the single interrupt line.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads zero, every match output is low and the interrupt line is low.
- R2: While running, the counter advances once every (prescale + 1) clocks, so prescale 0 means one step per clock. The prescale value is at word 1 and the counter is read at word 2.
- R3: Control word 0 has bit 0 as the run bit and bit 1 as a clear strobe. With bit 0 clear the counter holds its value. Writing 1 to bit 1 zeroes the counter and the prescaler. Setting the run bit alone resumes counting from the held value.
- R4: Word 3 gives each match channel n three bits starting at bit 3n: wrap (3n), halt (3n+1) and flag (3n+2). A channel fires on a step where the counter equals its match value (word 8+n). When it fires with wrap set, the counter becomes 0, so it cycles through 0 to the match value inclusive.
- R5: When a channel fires with halt set, the run bit is cleared and the counter keeps the match value.
- R6: Word 4 holds the output levels in bits [3:0] and a 2-bit action for channel n at bit 4+2n. The actions are 0 keep, 1 low, 2 high and 3 toggle, and each is applied when the channel fires. Writing word 4 loads the levels directly.
- R7: Word 5 bit n makes channel n a PWM output. Such an output is low while the counter is below the match value and high from the match value upward. A match value above the period value keeps the output low for the whole period.
- R8: Word 6 gives each capture channel c three bits starting at bit 3c: rising edge (3c), falling edge (3c+1) and flag (3c+2). An input change first sampled on clock edge E stores the counter value that holds between edges E+1 and E+2 into word 12+c. An edge that is not enabled stores nothing.
- R9: Status word 7 holds the match flags in bits [3:0] and capture flag c in bit 4+c. A flag is set only if its flag-enable bit is set. The interrupt line is high whenever any status bit is 1.
- R10: Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged. A flag raised on the same edge as a clear remains set.
- R11: When a channel with both wrap and flag set fires, the counter returns to 0 and the flag appears on the same edge.
- R12: The match values (words 8 to 11) and the configuration words read back what was written. Writes to the counter word and to the capture words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| cap_in | input | NC (2) | Asynchronous capture inputs |
| mat_out | output | NM (4) | Match / PWM outputs |
| irq | output | 1 | Interrupt, high while any status flag is set |

## Verification
A single clock edge can carry both a software clear of a match flag and a new firing of the same channel. The bench provokes this by running the counter with a short wrapping period and a wrap-and-flag channel. It times a write-one-to-clear so the write is sampled on exactly the edge where the counter hits the period value, and then reads the status word. A flag still set there confirms that setting wins. The clear issued one edge later must empty the word, and the counter must read 0 on the firing edge, which confirms that the wrap and the flag happen together.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int DW = 32;
    localparam int AW = 4;

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_PRESC  = 4'd1;
    localparam logic [AW-1:0] A_COUNT  = 4'd2;
    localparam logic [AW-1:0] A_MCTL   = 4'd3;
    localparam logic [AW-1:0] A_EXTM   = 4'd4;
    localparam logic [AW-1:0] A_PWMC   = 4'd5;
    localparam logic [AW-1:0] A_CCTL   = 4'd6;
    localparam logic [AW-1:0] A_STAT   = 4'd7;
    localparam logic [AW-1:0] A_MVAL0  = 4'd8;
    localparam logic [AW-1:0] A_CAPV0  = 4'd12;

    localparam int CTRL_RUN = 0;
    localparam int CTRL_CLR = 1;

    typedef enum logic [1:0] {
        EXT_KEEP   = 2'd0,
        EXT_LOW    = 2'd1,
        EXT_HIGH   = 2'd2,
        EXT_TOGGLE = 2'd3
    } ext_act_e;

    // per match channel action bits, lsb first: wrap, halt, flag
    typedef struct packed {
        logic flag;
        logic halt;
        logic wrap;
    } match_act_t;

    // per capture channel bits, lsb first: rising, falling, flag
    typedef struct packed {
        logic flag;
        logic fall;
        logic rise;
    } cap_cfg_t;

    function automatic logic ext_next(ext_act_e act, logic cur);
        case (act)
            EXT_LOW:    return 1'b0;
            EXT_HIGH:   return 1'b1;
            EXT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic logic [AW-1:0] word_at(logic [AW-1:0] base, int idx);
        return base + idx[AW-1:0];
    endfunction

endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    logic [PW-1:0] pcnt;

    assign tick = run && (pcnt >= presc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit
    import mct_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] mval,
    input  ext_act_e      act,
    input  logic          pwm_en,
    input  logic          st_wr,
    input  logic          st_wdata,
    output logic          hit,
    output logic          ext_q,
    output logic          mat_out
);
    assign hit = step && (cnt == mval);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
        end else if (st_wr) begin
            ext_q <= st_wdata;
        end else if (hit) begin
            ext_q <= ext_next(act, ext_q);
        end
    end

    // PWM level: low below the match value, high from it upward
    assign mat_out = pwm_en ? (cnt >= mval) : ext_q;
endmodule

// File: rtl/mct_capture_unit.sv
module mct_capture_unit #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin,
    input  logic          rise_en,
    input  logic          fall_en,
    input  logic [CW-1:0] cnt,
    output logic          evt,
    output logic [CW-1:0] capv
);
    // [0],[1]: synchronizer, [2]: previous synchronized level
    logic [2:0] sh;
    logic       rose, fell;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], pin};
    end

    assign rose = sh[1] & ~sh[2];
    assign fell = ~sh[1] & sh[2];
    assign evt  = (rose & rise_en) | (fell & fall_en);

    always_ff @(posedge clk) begin
        if (rst)      capv <= '0;
        else if (evt) capv <= cnt;
    end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int NM = 4,
    parameter int NC = 2,
    parameter int CW = 16,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NC-1:0] cap_in,
    output logic [NM-1:0] mat_out,
    output logic          irq
);
    localparam int NF = NM + NC;

    logic            run;
    logic [PW-1:0]   presc;
    logic [CW-1:0]   cnt;
    logic [3*NM-1:0] mctl;
    logic [2*NM-1:0] ext_act;
    logic [NM-1:0]   pwm_en;
    logic [3*NC-1:0] cctl;
    logic [NF-1:0]   status;
    logic [CW-1:0]   mval [NM];
    logic [CW-1:0]   capv [NC];

    logic [NM-1:0]   hit, ext_q, rst_en, stop_en, irq_en;
    logic [NC-1:0]   cap_evt, cap_irq;
    logic            tick, count_step, any_wrap, any_halt, clr_req;
    logic            wr_ctrl, wr_presc, wr_mctl, wr_extm, wr_pwmc, wr_cctl, wr_stat;
    logic [NF-1:0]   clr_mask, set_mask;
    wire             unused_wdata = ^bus_wdata;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_presc = bus_wr && (bus_addr == A_PRESC);
    assign wr_mctl  = bus_wr && (bus_addr == A_MCTL);
    assign wr_extm  = bus_wr && (bus_addr == A_EXTM);
    assign wr_pwmc  = bus_wr && (bus_addr == A_PWMC);
    assign wr_cctl  = bus_wr && (bus_addr == A_CCTL);
    assign wr_stat  = bus_wr && (bus_addr == A_STAT);
    assign clr_req  = wr_ctrl && bus_wdata[CTRL_CLR];

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            presc   <= '0;
            mctl    <= '0;
            ext_act <= '0;
            pwm_en  <= '0;
            cctl    <= '0;
        end else begin
            if (wr_presc) presc   <= bus_wdata[PW-1:0];
            if (wr_mctl)  mctl    <= bus_wdata[3*NM-1:0];
            if (wr_extm)  ext_act <= bus_wdata[NM +: 2*NM];
            if (wr_pwmc)  pwm_en  <= bus_wdata[NM-1:0];
            if (wr_cctl)  cctl    <= bus_wdata[3*NC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NM; i++) mval[i] <= '0;
        end else begin
            for (int i = 0; i < NM; i++)
                if (bus_wr && bus_addr == word_at(A_MVAL0, i)) mval[i] <= bus_wdata[CW-1:0];
        end
    end

    mct_prescaler #(.PW(PW)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .clr   (clr_req),
        .presc (presc),
        .tick  (tick)
    );

    assign count_step = run && tick;

    genvar n;
    generate
        for (n = 0; n < NM; n++) begin : g_match
            match_act_t cfg;
            assign cfg        = match_act_t'(mctl[3*n +: 3]);
            assign rst_en[n]  = cfg.wrap;
            assign stop_en[n] = cfg.halt;
            assign irq_en[n]  = cfg.flag;

            mct_match_unit #(.CW(CW)) u_mu (
                .clk      (clk),
                .rst      (rst),
                .step     (count_step),
                .cnt      (cnt),
                .mval     (mval[n]),
                .act      (ext_act_e'(ext_act[2*n +: 2])),
                .pwm_en   (pwm_en[n]),
                .st_wr    (wr_extm),
                .st_wdata (bus_wdata[n]),
                .hit      (hit[n]),
                .ext_q    (ext_q[n]),
                .mat_out  (mat_out[n])
            );
        end

        for (n = 0; n < NC; n++) begin : g_cap
            cap_cfg_t cfg;
            assign cfg        = cap_cfg_t'(cctl[3*n +: 3]);
            assign cap_irq[n] = cfg.flag;

            mct_capture_unit #(.CW(CW)) u_cu (
                .clk     (clk),
                .rst     (rst),
                .pin     (cap_in[n]),
                .rise_en (cfg.rise),
                .fall_en (cfg.fall),
                .cnt     (cnt),
                .evt     (cap_evt[n]),
                .capv    (capv[n])
            );
        end
    endgenerate

    assign any_wrap = |(hit & rst_en);
    assign any_halt = |(hit & stop_en);

    // counter and run bit; a bus write to the control word overrides a halt
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            if (wr_ctrl)       run <= bus_wdata[CTRL_RUN];
            else if (any_halt) run <= 1'b0;

            if (clr_req)                      cnt <= '0;
            else if (any_wrap)                cnt <= '0;
            else if (count_step && !any_halt) cnt <= cnt + 1'b1;
        end
    end

    // status: hardware set has priority over software clear
    assign clr_mask = wr_stat ? bus_wdata[NF-1:0] : '0;
    assign set_mask = {cap_evt & cap_irq, hit & irq_en};

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_mask) | set_mask;
    end

    assign irq = |status;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[CTRL_RUN] = run;
            A_PRESC: bus_rdata[PW-1:0]   = presc;
            A_COUNT: bus_rdata[CW-1:0]   = cnt;
            A_MCTL:  bus_rdata[3*NM-1:0] = mctl;
            A_EXTM:  bus_rdata[3*NM-1:0] = {ext_act, ext_q};
            A_PWMC:  bus_rdata[NM-1:0]   = pwm_en;
            A_CCTL:  bus_rdata[3*NC-1:0] = cctl;
            A_STAT:  bus_rdata[NF-1:0]   = status;
            default: ;
        endcase
        for (int i = 0; i < NM; i++)
            if (bus_addr == word_at(A_MVAL0, i)) bus_rdata[CW-1:0] = mval[i];
        for (int i = 0; i < NC; i++)
            if (bus_addr == word_at(A_CAPV0, i)) bus_rdata[CW-1:0] = capv[i];
    end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
    parameter int NM = 4,
    parameter int NC = 2,
    parameter int CW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             step,
    input logic             ctrl_wr,
    input logic [CW-1:0]    cnt,
    input logic [NM-1:0]    hit,
    input logic [NM-1:0]    rst_en,
    input logic [NM-1:0]    stop_en,
    input logic [NM-1:0]    irq_en,
    input logic [NC-1:0]    cap_evt,
    input logic [NC-1:0]    cap_irq,
    input logic [NM+NC-1:0] status
);
    // R2 / R3: the counter only moves on a step or a control write
    p_idle_holds_count_r3: assert property (@(posedge clk) disable iff (rst)
        (!step && !ctrl_wr) |=> $stable(cnt));

    // R4 / R11: a wrapping channel returns the counter to zero
    p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (|(hit & rst_en)) |=> (cnt == '0));

    // R5: halt clears run and freezes the counter at the match value
    p_halt_freezes_r5: assert property (@(posedge clk) disable iff (rst)
        ((|(hit & stop_en)) && !(|(hit & rst_en)) && !ctrl_wr) |=> (!run && $stable(cnt)));

    // R9 / R10: an enabled match raises its flag regardless of a clear
    p_match_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (|(hit & irq_en)) |=>
            ((status[NM-1:0] & $past(hit & irq_en)) == $past(hit & irq_en)));

    // R8: an enabled capture event raises its flag
    p_cap_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (|(cap_evt & cap_irq)) |=>
            ((status[NM+NC-1:NM] & $past(cap_evt & cap_irq)) == $past(cap_evt & cap_irq)));
endmodule

bind mct_timer mct_timer_chk #(.NM(NM), .NC(NC), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .step    (count_step),
    .ctrl_wr (wr_ctrl),
    .cnt     (cnt),
    .hit     (hit),
    .rst_en  (rst_en),
    .stop_en (stop_en),
    .irq_en  (irq_en),
    .cap_evt (cap_evt),
    .cap_irq (cap_irq),
    .status  (status)
);

// File: tb/sim_mct_timer.sv
module sim_mct_timer;
    import mct_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic [3:0]  mat_out;
    logic        irq;

    int          nvec = 0;
    int          nbad = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    mct_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cap_in    (cap_in),
        .mat_out   (mat_out),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired, run incomplete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            chk($sformatf("R1 reset word %0d", a), v, 0);
        end
        chk("R1 mat_out", mat_out, 0);
        chk("R1 irq", irq, 0);

        // R12: readback and read-only words
        wr(A_COUNT, 32'h55); rd(A_COUNT, v); chk("R12 count read-only", v, 0);
        wr(A_CAPV0, 32'h77); rd(A_CAPV0, v); chk("R12 capture read-only", v, 0);
        wr(word_at(A_MVAL0, 2), 32'h1234); rd(word_at(A_MVAL0, 2), v); chk("R12 match value", v, 32'h1234);
        wr(A_EXTM, 32'hABC); rd(A_EXTM, v); chk("R12 R6 ext word", v, 32'hABC);
        wr(A_EXTM, 0);
        wr(A_CCTL, 32'h2D); rd(A_CCTL, v); chk("R12 capture ctrl", v, 32'h2D);
        wr(A_PRESC, 32'h5A); rd(A_PRESC, v); chk("R12 prescale", v, 32'h5A);

        // R2 R4 R7: prescale / period / duty sweep
        for (int pr = 0; pr < 4; pr++)
            for (int p = 1; p < 5; p++)
                for (int m = 0; m <= p + 1; m++) begin
                    wr(A_CTRL, 0);
                    wr(A_PRESC, pr);
                    wr(A_MCTL, 32'h1 << 9);
                    wr(A_PWMC, 32'h3);
                    wr(word_at(A_MVAL0, 3), p);
                    wr(word_at(A_MVAL0, 0), m);
                    wr(word_at(A_MVAL0, 1), p + 5);
                    wr(A_CTRL, 3);
                    for (int k = 0; k < 2 * (p + 1) * (pr + 1); k++) begin
                        int c;
                        if (k > 0) step();
                        c = (k / (pr + 1)) % (p + 1);
                        rd(A_COUNT, v);
                        chk($sformatf("R2 R4 count pr=%0d p=%0d k=%0d", pr, p, k), v, c);
                        chk($sformatf("R7 pwm pr=%0d p=%0d m=%0d k=%0d", pr, p, m, k), mat_out[0], (c >= m));
                        chk("R7 zero duty", mat_out[1], 0);
                    end
                end

        // R6: external output actions, channel 0 value 1, period 3
        for (int act = 0; act < 4; act++)
            for (int init = 0; init < 2; init++) begin
                wr(A_CTRL, 0);
                wr(A_PRESC, 0);
                wr(A_MCTL, 32'h1 << 9);
                wr(A_PWMC, 0);
                wr(word_at(A_MVAL0, 3), 3);
                wr(word_at(A_MVAL0, 0), 1);
                wr(A_EXTM, init | (act << 4));
                wr(A_CTRL, 3);
                for (int k = 0; k < 16; k++) begin
                    int  nf;
                    logic e;
                    if (k > 0) step();
                    nf = (k >= 2) ? (k - 2) / 4 + 1 : 0;
                    case (act)
                        1:       e = (nf > 0) ? 1'b0 : init[0];
                        2:       e = (nf > 0) ? 1'b1 : init[0];
                        3:       e = init[0] ^ nf[0];
                        default: e = init[0];
                    endcase
                    chk($sformatf("R6 act=%0d init=%0d k=%0d", act, init, k), mat_out[0], e);
                end
            end

        // R9 R10 R11: wrap+flag on channel 3, period 2
        wr(A_CTRL, 0);
        wr(A_STAT, 32'h3F);
        wr(A_MCTL, (32'h1 << 9) | (32'h1 << 11));
        wr(word_at(A_MVAL0, 3), 2);
        wr(A_PRESC, 0);
        chk("R9 irq idle", irq, 0);
        wr(A_CTRL, 3);                       // after e0
        step(); step();                      // after e0+2
        chk("R11 no flag before hit", irq, 0);
        rd(A_COUNT, v); chk("R11 count at period", v, 2);
        step();                              // after e0+3
        chk("R11 flag on wrap", irq, 1);
        rd(A_COUNT, v); chk("R11 count wrapped", v, 0);
        rd(A_STAT, v); chk("R9 match flag bit", v, 32'h8);
        wr(A_STAT, 32'h1);                   // edge e0+4
        rd(A_STAT, v); chk("R10 zero bits keep flag", v, 32'h8);
        wr(A_STAT, 32'h8);                   // edge e0+5
        rd(A_STAT, v); chk("R10 clear", v, 0);
        wr(A_STAT, 32'h8);                   // edge e0+6 coincides with a hit
        rd(A_STAT, v); chk("R10 set wins over clear", v, 32'h8);
        wr(A_STAT, 32'h8);                   // edge e0+7
        rd(A_STAT, v); chk("R10 clear after collision", v, 0);
        chk("R9 irq low", irq, 0);
        wr(A_CTRL, 0);                       // edge e0+8: last step to 2
        rd(A_COUNT, v); chk("R3 halted value", v, 2);
        repeat (6) step();
        rd(A_COUNT, v); chk("R3 halt holds", v, 2);

        // R5: halt on channel 2 at value 5, prescale 1, no flag enable
        wr(A_STAT, 32'h3F);
        wr(A_PRESC, 1);
        wr(A_MCTL, 32'h1 << 7);
        wr(word_at(A_MVAL0, 2), 5);
        wr(A_CTRL, 3);
        repeat (30) step();
        rd(A_COUNT, v); chk("R5 count frozen", v, 5);
        rd(A_CTRL, v); chk("R5 run cleared", v, 0);
        rd(A_STAT, v); chk("R9 no flag without enable", v, 0);

        // R8: capture with halted counter at 5
        wr(A_CCTL, 32'h15);                  // ch0 rise+flag, ch1 fall
        wr(A_STAT, 32'h3F);
        cap_in[1] = 1'b1;
        repeat (4) step();
        rd(word_at(A_CAPV0, 1), v); chk("R8 rise ignored on fall-only", v, 0);
        rd(A_STAT, v); chk("R8 no flag", v, 0);
        cap_in[0] = 1'b1;
        repeat (4) step();
        rd(A_CAPV0, v); chk("R8 rise capture", v, 5);
        rd(A_STAT, v); chk("R8 R9 capture flag", v, 32'h10);
        wr(A_STAT, 32'h10);
        wr(A_MCTL, 0);
        wr(A_CTRL, 1);                       // resume without clear
        repeat (3) step();
        wr(A_CTRL, 0);
        rd(A_COUNT, v); chk("R3 resume from held value", v, 7);
        cap_in[1] = 1'b0;
        repeat (4) step();
        rd(word_at(A_CAPV0, 1), v); chk("R8 fall capture", v, 7);
        rd(A_STAT, v); chk("R9 capture flag needs enable", v, 0);
        cap_in[0] = 1'b0;
        repeat (4) step();
        rd(A_CAPV0, v); chk("R8 fall ignored on rise-only", v, 5);

        // R8: capture latency against a running counter
        wr(A_PRESC, 0);
        wr(A_CTRL, 3);
        repeat (10) step();
        cap_in[0] = 1'b1;
        repeat (5) step();
        rd(A_CAPV0, v); chk("R8 synchronizer latency", v, 12);
        rd(A_STAT, v); chk("R8 R9 flag on running capture", v, 32'h10);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule